// File: doc/BRIEF.md
# Serial FIFO Extension Controller

This block sits between a host bus and a 16550-style UART core. It adds a deep receive queue and a deep transmit queue, a status byte, a set of maskable interrupt sources folded onto one interrupt line, and an interval timer with a fixed tick. The host reaches it through a byte-wide register port with a 3-bit address and separate read and write strobes. The UART side has two byte streams with valid/ready handshakes. Received bytes flow into the receive queue, and transmit bytes flow out of the transmit queue. Each stream has its own blocking input.

Each interrupt source clears in its own way. The receive half-full source follows the queue level. The character timeout clears on a status read or a data read. The transmit empty source clears on a status read or a data write. The transmit half-full source clears on a status read or when the queue is refilled to half. The timer source stays set until software turns the timer off. The interrupt line can be a level or a single-cycle pulse for each newly pending enabled source.

Register offsets: 0 mode, 1 interrupt enable, 2 status (read) and queue flush (write), 3 timer interval, 4 timer control, 5 data (a read pops the receive queue, a write pushes the transmit queue).

Top module: `serial_fifo_ext`

## Requirements
- R1: After reset, a read at offset 2 returns 0x29, a read at offset 0 returns 0, and irq is low.
- R2: Mode bits 0 (half swap), 2 (queue enable), 3 (auto flow) and 4 (1 = level interrupt, 0 = pulse) read back as written. Bit 1 always reads 0. Bit 3 drives autoFlowEn.
- R3: While mode bit 2 is 0, rxInReady and txOutValid stay low.
- R4: Both queues keep byte order. Status bits: 4 = receive count at least DEPTH/2, 3 = receive empty, 2 = transmit full, 1 = transmit count at least DEPTH/2, 0 = transmit empty.
- R5: rxBlock high forces rxInReady low, and txBlock high forces txOutValid low.
- R6: A full receive queue reads status bit 5 as 0 (active low) and holds rxInReady low.
- R7: Any write to offset 2 empties both queues by the next cycle.
- R8: With timer control bit 0 set, status bit 7 sets after interval × TICK_DIV cycles. It stays set while the timer is enabled and clears once bit 0 is written 0.
- R9: Writing 0 to offset 3 stores 1, and offset 3 then reads back 1.
- R10: Status bit 6 sets when the receive queue is non-empty with no arrival or pop for CTO_TICKS × TICK_DIV cycles. It clears on a status read or on a data read.
- R11: Transmit-empty (enable bit 2) pends when the transmit queue drains and clears on a status read or a data write. Transmit-half (enable bit 1) pends when the count drops below half and clears when writes bring it back to half.
- R12: Receive-half (enable bit 0) is asserted while the receive count is at least DEPTH/2 and drops once reads bring it below.
- R13: In pulse mode, irq is high for exactly one cycle when a new enabled source becomes pending.
- R14: With mode bit 0 set, each group of 16 transmit bytes leaves as bytes 8..15 followed by 0..7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hostAddr | input | 3 | Register offset |
| hostWr | input | 1 | Write strobe |
| hostRd | input | 1 | Read strobe (side effects only; data is combinational) |
| hostWdata | input | 8 | Write data |
| hostRdata | output | 8 | Read data for hostAddr |
| irq | output | 1 | Interrupt line |
| autoFlowEn | output | 1 | Auto flow-control enable for the UART pins |
| rxInValid | input | 1 | UART has a received byte |
| rxInData | input | 8 | Received byte |
| rxInReady | output | 1 | Receive queue accepts a byte |
| rxBlock | input | 1 | Blocks UART-to-queue transfers |
| txOutValid | output | 1 | Transmit byte available |
| txOutData | output | 8 | Transmit byte |
| txOutReady | input | 1 | UART takes the transmit byte |
| txBlock | input | 1 | Blocks queue-to-UART transfers |

## Verification
A corrupted queue pointer or count shows as reordered or lost bytes at the data port or at txOutData. It also shows as a wrong status byte on the very next status read. A pending flag stuck high or low shows on irq within two cycles of the triggering event in level mode. The same fault shows as a missing or repeated pulse in pulse mode. Timer and timeout counters that run early or late move the irq edge by whole ticks, and the bench catches this with bounded windows on either side of the expected cycle.

// File: rtl/sfx_pkg.sv
package sfx_pkg;
  localparam logic [2:0] ADDR_MODE = 3'd0;
  localparam logic [2:0] ADDR_IEN  = 3'd1;
  localparam logic [2:0] ADDR_STAT = 3'd2;
  localparam logic [2:0] ADDR_IVAL = 3'd3;
  localparam logic [2:0] ADDR_TCTL = 3'd4;
  localparam logic [2:0] ADDR_DATA = 3'd5;

  // control -> datapath strobes
  typedef struct packed {
    logic       rxPop;
    logic       txPush;
    logic [7:0] txData;
    logic       flush;
    logic       fifoEn;
    logic       swapEn;
  } sfxStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic       rxEmpty;
    logic       rxHalf;
    logic       rxFull;
    logic       txEmpty;
    logic       txHalf;
    logic       txFull;
    logic       rxArrive;
    logic [7:0] rxHead;
  } sfxStatus_t;
endpackage

// File: rtl/sfx_fifo.sv
module sfx_fifo #(
  parameter int DEPTH = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       flush,
  input  logic       push,
  input  logic [7:0] pushData,
  input  logic       pop,
  input  logic       swapEn,
  output logic [7:0] popData,
  output logic       canPush,
  output logic       canPop,
  output logic       empty,
  output logic       half
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] CAP_PLAIN = CW'(DEPTH);
  localparam logic [CW-1:0] CAP_SWAP  = CW'(DEPTH - 8);
  localparam logic [CW-1:0] HALF_LVL  = CW'(DEPTH / 2);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr, rdAddr;
  logic [CW-1:0] cnt;
  logic          doPush, doPop;

  // swapped read: slot rdPtr^8 must already be written
  assign rdAddr  = swapEn ? (rdPtr ^ AW'(8)) : rdPtr;
  assign canPop  = swapEn ? (rdPtr[3] ? (cnt != '0) : (cnt >= CW'(9))) : (cnt != '0);
  assign canPush = cnt < (swapEn ? CAP_SWAP : CAP_PLAIN);
  assign empty   = (cnt == '0);
  assign half    = (cnt >= HALF_LVL);
  assign popData = mem[rdAddr];
  assign doPush  = push && canPush && !flush;
  assign doPop   = pop && canPop && !flush;

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= pushData;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      cnt   <= '0;
    end else begin
      if (doPush) wrPtr <= wrPtr + AW'(1);
      if (doPop)  rdPtr <= rdPtr + AW'(1);
      cnt <= cnt + CW'(doPush) - CW'(doPop);
    end
  end
endmodule

// File: rtl/sfx_datapath.sv
module sfx_datapath
  import sfx_pkg::*;
#(
  parameter int DEPTH = 1024
) (
  input  logic       clk,
  input  logic       rst_n,
  input  sfxStrobe_t strb,
  output sfxStatus_t stat,
  input  logic       rxInValid,
  input  logic [7:0] rxInData,
  output logic       rxInReady,
  input  logic       rxBlock,
  output logic       txOutValid,
  output logic [7:0] txOutData,
  input  logic       txOutReady,
  input  logic       txBlock
);
  logic rxCanPush, rxCanPop, rxEmpty, rxHalf, rxPush;
  logic txCanPush, txCanPop, txEmpty, txHalf, txPop;
  logic [7:0] rxHead;

  assign rxInReady  = strb.fifoEn && rxCanPush && !rxBlock;
  assign rxPush     = rxInValid && rxInReady;
  assign txOutValid = strb.fifoEn && txCanPop && !txBlock;
  assign txPop      = txOutValid && txOutReady;

  sfx_fifo #(.DEPTH(DEPTH)) rxFifo (
    .clk(clk), .rst_n(rst_n), .flush(strb.flush),
    .push(rxPush), .pushData(rxInData),
    .pop(strb.rxPop && rxCanPop), .swapEn(1'b0),
    .popData(rxHead), .canPush(rxCanPush), .canPop(rxCanPop),
    .empty(rxEmpty), .half(rxHalf)
  );

  sfx_fifo #(.DEPTH(DEPTH)) txFifo (
    .clk(clk), .rst_n(rst_n), .flush(strb.flush),
    .push(strb.txPush), .pushData(strb.txData),
    .pop(txPop), .swapEn(strb.swapEn),
    .popData(txOutData), .canPush(txCanPush), .canPop(txCanPop),
    .empty(txEmpty), .half(txHalf)
  );

  always_comb begin
    stat.rxEmpty  = rxEmpty;
    stat.rxHalf   = rxHalf;
    stat.rxFull   = !rxCanPush;
    stat.txEmpty  = txEmpty;
    stat.txHalf   = txHalf;
    stat.txFull   = !txCanPush;
    stat.rxArrive = rxPush;
    stat.rxHead   = rxHead;
  end
endmodule

// File: rtl/sfx_control.sv
module sfx_control
  import sfx_pkg::*;
#(
  parameter int TICK_DIV  = 40000,
  parameter int CTO_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hostAddr,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic       irq,
  output logic       autoFlowEn,
  input  sfxStatus_t stat,
  output sfxStrobe_t strb
);
  localparam int TW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam int CTO_CYCLES = TICK_DIV * CTO_TICKS;
  localparam int CCW = $clog2(CTO_CYCLES + 1);
  localparam logic [TW-1:0]  PRESC_LAST = TW'(TICK_DIV - 1);
  localparam logic [CCW-1:0] CTO_LIMIT  = CCW'(CTO_CYCLES);

  logic [4:0]     modeQ, ienQ, srcVec, srcPrevQ;
  logic [7:0]     ivalQ, ivCntQ;
  logic [TW-1:0]  prescQ;
  logic [CCW-1:0] ctoCntQ;
  logic tmrEnQ, timerPend, ctoPend, txEmptyPend, txHalfPend;
  logic txEmptyPrev, txHalfPrev, irqQ;
  logic statRd, dataRd, dataWr, ctoHit;

  assign statRd = hostRd && hostAddr == ADDR_STAT;
  assign dataRd = hostRd && hostAddr == ADDR_DATA && !stat.rxEmpty;
  assign dataWr = hostWr && hostAddr == ADDR_DATA;

  always_comb begin
    strb.rxPop  = dataRd;
    strb.txPush = dataWr;
    strb.txData = hostWdata;
    strb.flush  = hostWr && hostAddr == ADDR_STAT;
    strb.fifoEn = modeQ[2];
    strb.swapEn = modeQ[0];
  end
  assign autoFlowEn = modeQ[3];
  assign irq = irqQ;

  // register file
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      modeQ  <= '0;
      ienQ   <= '0;
      ivalQ  <= 8'd1;
      tmrEnQ <= 1'b0;
    end else if (hostWr) begin
      case (hostAddr)
        ADDR_MODE: modeQ  <= hostWdata[4:0] & 5'b11101;
        ADDR_IEN:  ienQ   <= hostWdata[4:0];
        ADDR_IVAL: ivalQ  <= (hostWdata == 8'd0) ? 8'd1 : hostWdata;
        ADDR_TCTL: tmrEnQ <= hostWdata[0];
        default: ;
      endcase
    end
  end

  // interval timer: pends after ivalQ ticks, holds until disabled
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prescQ    <= '0;
      ivCntQ    <= '0;
      timerPend <= 1'b0;
    end else if (!tmrEnQ) begin
      prescQ    <= '0;
      ivCntQ    <= '0;
      timerPend <= 1'b0;
    end else if (!timerPend) begin
      if (prescQ == PRESC_LAST) begin
        prescQ <= '0;
        if (ivCntQ == ivalQ - 8'd1) begin
          ivCntQ    <= '0;
          timerPend <= 1'b1;
        end else begin
          ivCntQ <= ivCntQ + 8'd1;
        end
      end else begin
        prescQ <= prescQ + TW'(1);
      end
    end
  end

  // character timeout: fires once per quiet period
  assign ctoHit = (ctoCntQ == CTO_LIMIT - CCW'(1));
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctoCntQ <= '0;
      ctoPend <= 1'b0;
    end else begin
      if (stat.rxArrive || dataRd || stat.rxEmpty) ctoCntQ <= '0;
      else if (ctoCntQ != CTO_LIMIT) ctoCntQ <= ctoCntQ + CCW'(1);
      if (ctoHit && !(stat.rxArrive || dataRd || stat.rxEmpty)) ctoPend <= 1'b1;
      else if (statRd || dataRd) ctoPend <= 1'b0;
    end
  end

  // transmit-side sources
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txEmptyPrev <= 1'b1;
      txHalfPrev  <= 1'b0;
      txEmptyPend <= 1'b0;
      txHalfPend  <= 1'b0;
    end else begin
      txEmptyPrev <= stat.txEmpty;
      txHalfPrev  <= stat.txHalf;
      if (stat.txEmpty && !txEmptyPrev) txEmptyPend <= 1'b1;
      else if (dataWr || statRd) txEmptyPend <= 1'b0;
      if (!stat.txHalf && txHalfPrev) txHalfPend <= 1'b1;
      else if (stat.txHalf || statRd) txHalfPend <= 1'b0;
    end
  end

  // interrupt line
  assign srcVec = {timerPend, ctoPend, txEmptyPend, txHalfPend, stat.rxHalf} & ienQ;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srcPrevQ <= '0;
      irqQ     <= 1'b0;
    end else begin
      srcPrevQ <= srcVec;
      irqQ     <= modeQ[4] ? (|srcVec) : (|(srcVec & ~srcPrevQ));
    end
  end

  always_comb begin
    case (hostAddr)
      ADDR_MODE: hostRdata = {3'b000, modeQ};
      ADDR_IEN:  hostRdata = {3'b000, ienQ};
      ADDR_STAT: hostRdata = {timerPend, ctoPend, !stat.rxFull, stat.rxHalf,
                              stat.rxEmpty, stat.txFull, stat.txHalf, stat.txEmpty};
      ADDR_IVAL: hostRdata = ivalQ;
      ADDR_TCTL: hostRdata = {7'b0, tmrEnQ};
      ADDR_DATA: hostRdata = stat.rxHead;
      default:   hostRdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/serial_fifo_ext.sv
module serial_fifo_ext
  import sfx_pkg::*;
#(
  parameter int DEPTH     = 1024,
  parameter int TICK_DIV  = 40000,
  parameter int CTO_TICKS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] hostAddr,
  input  logic       hostWr,
  input  logic       hostRd,
  input  logic [7:0] hostWdata,
  output logic [7:0] hostRdata,
  output logic       irq,
  output logic       autoFlowEn,
  input  logic       rxInValid,
  input  logic [7:0] rxInData,
  output logic       rxInReady,
  input  logic       rxBlock,
  output logic       txOutValid,
  output logic [7:0] txOutData,
  input  logic       txOutReady,
  input  logic       txBlock
);
  sfxStrobe_t strb;
  sfxStatus_t stat;

  sfx_control #(.TICK_DIV(TICK_DIV), .CTO_TICKS(CTO_TICKS)) u_ctl (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .irq(irq), .autoFlowEn(autoFlowEn), .stat(stat), .strb(strb)
  );

  sfx_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .stat(stat),
    .rxInValid(rxInValid), .rxInData(rxInData), .rxInReady(rxInReady),
    .rxBlock(rxBlock), .txOutValid(txOutValid), .txOutData(txOutData),
    .txOutReady(txOutReady), .txBlock(txBlock)
  );
endmodule

// File: rtl/sfx_checker.sv
module sfx_checker (
  input logic       clk,
  input logic       rst_n,
  input logic [2:0] hostAddr,
  input logic       hostWr,
  input logic       rxInValid,
  input logic       rxInReady,
  input logic       rxBlock,
  input logic       txOutValid,
  input logic       txBlock,
  input logic       fifoEn,
  input logic       rxEmpty,
  input logic       rxFull,
  input logic       txEmpty
);
  AST_FIFO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !fifoEn |-> (!rxInReady && !txOutValid)); // R3
  AST_RX_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rxEmpty && !(rxInValid && rxInReady)) |=> rxEmpty); // R4
  AST_RX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    rxBlock |-> !rxInReady); // R5
  AST_TX_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    txBlock |-> !txOutValid); // R5
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    rxFull |-> !rxInReady); // R6
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (hostWr && hostAddr == 3'd2) |=> (rxEmpty && txEmpty)); // R7
endmodule

bind serial_fifo_ext sfx_checker u_chk (
  .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWr(hostWr),
  .rxInValid(rxInValid), .rxInReady(rxInReady), .rxBlock(rxBlock),
  .txOutValid(txOutValid), .txBlock(txBlock), .fifoEn(strb.fifoEn),
  .rxEmpty(stat.rxEmpty), .rxFull(stat.rxFull), .txEmpty(stat.txEmpty)
);

// File: tb/serial_fifo_ext_test.sv
`timescale 1ns/1ps
module serial_fifo_ext_test;
  localparam int D = 32;
  localparam int TD = 4;
  localparam int CT = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] hostAddr = '0;
  logic hostWr = 1'b0, hostRd = 1'b0;
  logic [7:0] hostWdata = '0;
  logic [7:0] hostRdata;
  logic irq, autoFlowEn, rxInReady, txOutValid;
  logic rxInValid = 1'b0, rxBlock = 1'b0, txOutReady = 1'b0, txBlock = 1'b0;
  logic [7:0] rxInData = '0;
  logic [7:0] txOutData;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  serial_fifo_ext #(.DEPTH(D), .TICK_DIV(TD), .CTO_TICKS(CT)) uut (
    .clk(clk), .rst_n(rst_n), .hostAddr(hostAddr), .hostWr(hostWr),
    .hostRd(hostRd), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .irq(irq), .autoFlowEn(autoFlowEn), .rxInValid(rxInValid),
    .rxInData(rxInData), .rxInReady(rxInReady), .rxBlock(rxBlock),
    .txOutValid(txOutValid), .txOutData(txOutData),
    .txOutReady(txOutReady), .txBlock(txBlock)
  );

  function automatic logic [7:0] expStat(int rxn, int txn);
    return {2'b00, rxn != D, rxn >= D/2, rxn == 0, txn == D, txn >= D/2, txn == 0};
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hwr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); hostAddr = a; hostWdata = d; hostWr = 1'b1;
    @(negedge clk); hostWr = 1'b0;
  endtask

  task automatic hrd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk); hostAddr = a; hostRd = 1'b1; #1 d = hostRdata;
    @(negedge clk); hostRd = 1'b0;
  endtask

  task automatic upush(input logic [7:0] d);
    @(negedge clk); rxInValid = 1'b1; rxInData = d;
    @(negedge clk); rxInValid = 1'b0;
  endtask

  task automatic ttake(output logic [7:0] d, output logic ok);
    @(negedge clk); ok = txOutValid; d = txOutData; txOutReady = 1'b1;
    @(negedge clk); txOutReady = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v, q[$];
    logic ok;
    int n, m, cnt;
    void'($urandom(32'd4242));
    idle(4); rst_n = 1'b1; idle(2);

    // R1 reset state
    hrd(3'd2, v); chk("R1 status", v, 8'h29);
    hrd(3'd0, v); chk("R1 mode", v, 8'h00);
    chk("R1 irq", irq, 0);

    // R3 queues disabled
    #1 chk("R3 rxInReady", rxInReady, 0);
    hwr(3'd5, 8'hAA); #1 chk("R3 txOutValid", txOutValid, 0);
    hwr(3'd2, 8'h00);

    // R2 mode register
    hwr(3'd0, 8'hFF); hrd(3'd0, v); chk("R2 mode readback", v, 8'h1D);
    chk("R2 autoFlowEn", autoFlowEn, 1);
    hwr(3'd0, 8'h04); chk("R2 autoFlowEn off", autoFlowEn, 0);

    // R4 random traffic both directions
    for (int r = 0; r < 4; r++) begin
      n = $urandom_range(1, D);
      q.delete();
      for (int i = 0; i < n; i++) begin v = 8'($urandom); q.push_back(v); upush(v); end
      hrd(3'd2, v); chk("R4 rx status", v, expStat(n, 0));
      for (int i = 0; i < n; i++) begin hrd(3'd5, v); chk("R4 rx order", v, q[i]); end
      m = $urandom_range(1, D);
      q.delete(); txBlock = 1'b1;
      for (int i = 0; i < m; i++) begin v = 8'($urandom); q.push_back(v); hwr(3'd5, v); end
      hrd(3'd2, v); chk("R4 tx status", v, expStat(0, m));
      txBlock = 1'b0;
      for (int i = 0; i < m; i++) begin
        ttake(v, ok); chk("R4 tx valid", ok, 1); chk("R4 tx order", v, q[i]);
      end
      hrd(3'd2, v); chk("R4 drained", v, 8'h29);
    end

    // R5 gates
    rxBlock = 1'b1; #1 chk("R5 rx gate", rxInReady, 0);
    rxBlock = 1'b0; #1 chk("R5 rx open", rxInReady, 1);
    txBlock = 1'b1; hwr(3'd5, 8'h5A); #1 chk("R5 tx gate", txOutValid, 0);
    txBlock = 1'b0; #1 chk("R5 tx open", txOutValid, 1);
    ttake(v, ok); chk("R5 tx byte", v, 8'h5A);

    // R6 rx full, R7 flush
    txBlock = 1'b1;
    for (int i = 0; i < 3; i++) hwr(3'd5, 8'(i));
    for (int i = 0; i < D; i++) upush(8'(i));
    hrd(3'd2, v); chk("R6 full status", v, expStat(D, 3));
    chk("R6 ready low", rxInReady, 0);
    hwr(3'd2, 8'h00);
    hrd(3'd2, v); chk("R7 flushed", v, 8'h29);
    txBlock = 1'b0;

    // R8 timer
    hwr(3'd0, 8'h14); hwr(3'd1, 8'h10); hwr(3'd3, 8'd3);
    hwr(3'd4, 8'h01);
    idle(10); chk("R8 early irq", irq, 0);
    idle(4);  chk("R8 irq", irq, 1);
    idle(20); hrd(3'd2, v); chk("R8 held", v, 8'hA9);
    hwr(3'd4, 8'h00);
    hrd(3'd2, v); chk("R8 cleared", v, 8'h29);
    idle(1); chk("R8 irq low", irq, 0);

    // R9 zero interval
    hwr(3'd3, 8'd0); hrd(3'd3, v); chk("R9 readback", v, 8'd1);
    hwr(3'd4, 8'h01);
    idle(2); chk("R9 early", irq, 0);
    idle(4); chk("R9 fire", irq, 1);
    hwr(3'd4, 8'h00); hwr(3'd1, 8'h00);

    // R10 character timeout
    upush(8'h77); idle(20);
    hrd(3'd2, v); chk("R10 pending", v, 8'h61);
    hrd(3'd2, v); chk("R10 cleared by status", v, 8'h21);
    hrd(3'd5, v); chk("R10 data", v, 8'h77);
    upush(8'h78); idle(20);
    hrd(3'd5, v); hrd(3'd2, v); chk("R10 cleared by read", v, 8'h29);

    // R11 transmit sources
    hwr(3'd1, 8'h04);
    hwr(3'd5, 8'h11); ttake(v, ok);
    idle(2); chk("R11 empty irq", irq, 1);
    hrd(3'd2, v); idle(1); chk("R11 empty clear", irq, 0);
    hwr(3'd1, 8'h02); txBlock = 1'b1;
    for (int i = 0; i < D/2; i++) hwr(3'd5, 8'(i));
    txBlock = 1'b0; ttake(v, ok); txBlock = 1'b1;
    idle(2); chk("R11 half irq", irq, 1);
    hwr(3'd5, 8'hEE); idle(2); chk("R11 half clear", irq, 0);
    hwr(3'd1, 8'h00); hwr(3'd2, 8'h00); txBlock = 1'b0;

    // R12 receive half level
    hwr(3'd1, 8'h01);
    for (int i = 0; i < D/2; i++) upush(8'(i));
    idle(1); chk("R12 half irq", irq, 1);
    hrd(3'd5, v); idle(1); chk("R12 below half", irq, 0);
    hwr(3'd2, 8'h00);

    // R13 pulse mode
    hwr(3'd0, 8'h04);
    for (int i = 0; i < D/2; i++) upush(8'(i));
    cnt = 0;
    for (int i = 0; i < 6; i++) begin if (irq) cnt++; @(negedge clk); end
    chk("R13 single pulse", cnt, 1);
    hwr(3'd1, 8'h00); hwr(3'd2, 8'h00);

    // R14 half swap
    hwr(3'd0, 8'h05); txBlock = 1'b1;
    for (int i = 0; i < 16; i++) hwr(3'd5, 8'(i));
    txBlock = 1'b0;
    for (int i = 0; i < 16; i++) begin
      ttake(v, ok); chk("R14 valid", ok, 1); chk("R14 swapped order", v, i ^ 8);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule